// File: doc/BRIEF.md
# Elapsed-Time to Calendar Converter

This block turns a free-running elapsed-time value into calendar fields. The time value comes in two parts: a whole count of 2-second units and a fraction measured in 1/32768-second ticks. A one-cycle start request captures both parts. The block then works through a fixed sequence over several cycles and reports year, month, day, hour, minute and second.

The sequence runs in this order. A fixed epoch offset is removed from the unit count. Whole years are then taken off one per cycle, starting from a base year. Whole months of the final year are taken off next, using a month-length table and a leap rule in which every fourth year is a leap year. The rest is split into days, hours and minutes by repeated subtraction. The last step forms the seconds from the leftover units and the top bit of the fraction. A one-cycle done pulse marks the point where the outputs hold the result. The outputs then stay unchanged until the next accepted start.

The unit and fraction widths, the year width, the base year and the epoch offset are all parameters.

Top module: `elapsed_cal_conv`

## Requirements
- R1: After reset, busy and done are 0, year equals the base year (default 2000), month and day are 1, and hour, minute and second are 0.
- R2: A start seen while busy is 0 is accepted on that clock edge and captures units_in and frac_in. busy is 1 from the next cycle until the done cycle, inclusive.
- R3: The epoch offset (default 1000000 units) is subtracted from the captured count first, with 32-bit wraparound. A count equal to the offset converts to the base year, January 1, 00:00:00.
- R4: Years are removed one per step, starting at the base year. A year is 365 days, or 366 days when the year number is divisible by four. One day is 43200 units.
- R5: A year or month is removed only while the remainder is strictly greater than its length. A remainder exactly equal to the length stays in that year or month, which gives day 32 of December or of a 31-day month.
- R6: Month lengths in January-to-December order are 31,28,31,30,31,30,31,31,30,31,30,31 days, and February has 29 days in a leap year. Month is reported from 1 to 12.
- R7: The day is the remainder divided by 43200, plus 1. Hour and minute then come from dividing what is left by 1800 and by 30.
- R8: second equals twice the leftover units (0 to 29), plus 1 when frac_in is at least 32768 (bit 15 set).
- R9: done is a single-cycle pulse. It rises 7+Y+M+D+H+N clock edges after the accepting edge, where Y is years stepped, M is month-1, D is day-1, H is hour and N is minute.
- R10: A start seen while busy is 1, including in the done cycle, is ignored. It starts no conversion and does not change the result.
- R11: While idle with no start, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled when idle |
| units_in | input | CNT_W (32) | Elapsed count in 2-second units |
| frac_in | input | FRAC_W (16) | Fraction in 1/32768-second ticks |
| busy | output | 1 | Conversion in progress, done cycle included |
| done | output | 1 | One-cycle pulse, result valid |
| year | output | YEAR_W (16) | Calendar year |
| month | output | 4 | Month, 1 to 12 |
| day | output | 6 | Day of month, 1-based |
| hour | output | 5 | Hour, 0 to 23 |
| minute | output | 6 | Minute, 0 to 59 |
| second | output | 6 | Second, 0 to 59 |

## Verification
The case of interest is a start request that arrives in the same cycle the finished conversion is announced with done. To provoke it, the bench raises start right after it sees done and holds it across the edge that returns the block to idle. It then expects busy to stay low, no further done pulse, and the announced fields to stay unchanged. A second stress case places the remainder exactly on a year or month length. There the strict comparison and the step to the next field meet in one decision, and the scoreboard's independent model fixes the expected day-32 result.

// File: rtl/cal_conv_pkg.sv
package cal_conv_pkg;

  localparam logic [31:0] UNITS_DAY  = 32'd43200;
  localparam logic [31:0] UNITS_HOUR = 32'd1800;
  localparam logic [31:0] UNITS_MIN  = 32'd30;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_EPOCH,
    PH_YEAR,
    PH_MONTH,
    PH_DAY,
    PH_HOUR,
    PH_MIN,
    PH_SEC,
    PH_DONE
  } phase_e;

  // every fourth year is long
  function automatic logic leap_of(input logic [1:0] yr_lo);
    return (yr_lo == 2'b00);
  endfunction

  // month length in days, index 0 = January
  function automatic logic [4:0] days_in_month(input logic [3:0] idx, input logic leap);
    if (idx == 4'd1)
      return 5'd28 + {4'd0, leap};
    else if (idx < 4'd7)
      return 5'd30 + {4'd0, ~idx[0]};
    else
      return 5'd30 + {4'd0, idx[0]};
  endfunction

  function automatic logic [31:0] year_units(input logic leap);
    return (32'd365 + {31'd0, leap}) * UNITS_DAY;
  endfunction

  function automatic logic [31:0] month_units(input logic [3:0] idx, input logic leap);
    return {27'd0, days_in_month(idx, leap)} * UNITS_DAY;
  endfunction

endpackage

// File: rtl/cal_len_sel.sv
module cal_len_sel
  import cal_conv_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  phase_e             phase,
  input  logic [1:0]         yr_lo,
  input  logic [3:0]         mon_idx,
  output logic [CNT_W-1:0]   len,
  output logic               strict
);

  logic leap;
  assign leap = leap_of(yr_lo);

  always_comb begin
    case (phase)
      PH_YEAR:  len = CNT_W'(year_units(leap));
      PH_MONTH: len = CNT_W'(month_units(mon_idx, leap));
      PH_DAY:   len = CNT_W'(UNITS_DAY);
      PH_HOUR:  len = CNT_W'(UNITS_HOUR);
      PH_MIN:   len = CNT_W'(UNITS_MIN);
      default:  len = '1;
    endcase
  end

  // calendar units use strict comparison, time-of-day uses inclusive
  assign strict = (phase == PH_YEAR) || (phase == PH_MONTH);

endmodule

// File: rtl/cal_peel.sv
module cal_peel #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] len,
  input  logic         strict,
  output logic         take,
  output logic [W-1:0] diff
);

  logic gt, eq;
  assign gt   = rem > len;
  assign eq   = rem == len;
  assign take = gt || (!strict && eq);
  assign diff = rem - len;

endmodule

// File: rtl/elapsed_cal_conv.sv
module elapsed_cal_conv
  import cal_conv_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter int unsigned      FRAC_W     = 16,
  parameter int unsigned      YEAR_W     = 16,
  parameter int unsigned      EPOCH_YEAR = 2000,
  parameter logic [CNT_W-1:0] EPOCH_OFS  = CNT_W'(1000000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  units_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              busy,
  output logic              done,
  output logic [YEAR_W-1:0] year,
  output logic [3:0]        month,
  output logic [5:0]        day,
  output logic [4:0]        hour,
  output logic [5:0]        minute,
  output logic [5:0]        second
);

  localparam logic [FRAC_W-1:0] FRAC_HALF = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [YEAR_W-1:0] YEAR_BASE = YEAR_W'(EPOCH_YEAR);

  phase_e             phase_q;
  logic [CNT_W-1:0]   rem_q;
  logic               frac_hi_q;
  logic [YEAR_W-1:0]  yr_q;
  logic [3:0]         mon_q;
  logic [4:0]         day_q;
  logic [4:0]         hr_q;
  logic [5:0]         min_q;
  logic [5:0]         sec_q;

  logic [CNT_W-1:0]   len_cur;
  logic               strict_cur;
  logic               take;
  logic [CNT_W-1:0]   diff;

  // named events for checking
  logic ev_accept, ev_ignore, ev_loop, ev_peel, ev_finish;

  cal_len_sel #(.CNT_W(CNT_W)) u_len (
    .phase   (phase_q),
    .yr_lo   (yr_q[1:0]),
    .mon_idx (mon_q),
    .len     (len_cur),
    .strict  (strict_cur)
  );

  cal_peel #(.W(CNT_W)) u_peel (
    .rem    (rem_q),
    .len    (len_cur),
    .strict (strict_cur),
    .take   (take),
    .diff   (diff)
  );

  assign ev_accept = (phase_q == PH_IDLE) && start;
  assign ev_ignore = (phase_q != PH_IDLE) && start;
  assign ev_loop   = (phase_q == PH_YEAR) || (phase_q == PH_MONTH) || (phase_q == PH_DAY)
                  || (phase_q == PH_HOUR) || (phase_q == PH_MIN);
  assign ev_peel   = ev_loop && take;
  assign ev_finish = (phase_q == PH_SEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      rem_q     <= '0;
      frac_hi_q <= 1'b0;
      yr_q      <= YEAR_BASE;
      mon_q     <= '0;
      day_q     <= '0;
      hr_q      <= '0;
      min_q     <= '0;
      sec_q     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            rem_q     <= units_in;
            frac_hi_q <= (frac_in >= FRAC_HALF);
            yr_q      <= YEAR_BASE;
            mon_q     <= '0;
            day_q     <= '0;
            hr_q      <= '0;
            min_q     <= '0;
            sec_q     <= '0;
            phase_q   <= PH_EPOCH;
          end
        end
        PH_EPOCH: begin
          rem_q   <= rem_q - EPOCH_OFS;
          phase_q <= PH_YEAR;
        end
        PH_YEAR: begin
          if (take) begin
            rem_q <= diff;
            yr_q  <= yr_q + YEAR_W'(1);
          end else begin
            phase_q <= PH_MONTH;
          end
        end
        PH_MONTH: begin
          if (take) begin
            rem_q <= diff;
            mon_q <= mon_q + 4'd1;
          end else begin
            phase_q <= PH_DAY;
          end
        end
        PH_DAY: begin
          if (take) begin
            rem_q <= diff;
            day_q <= day_q + 5'd1;
          end else begin
            phase_q <= PH_HOUR;
          end
        end
        PH_HOUR: begin
          if (take) begin
            rem_q <= diff;
            hr_q  <= hr_q + 5'd1;
          end else begin
            phase_q <= PH_MIN;
          end
        end
        PH_MIN: begin
          if (take) begin
            rem_q <= diff;
            min_q <= min_q + 6'd1;
          end else begin
            phase_q <= PH_SEC;
          end
        end
        PH_SEC: begin
          sec_q   <= {rem_q[4:0], frac_hi_q};
          phase_q <= PH_DONE;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign done   = (phase_q == PH_DONE);
  assign year   = yr_q;
  assign month  = mon_q + 4'd1;
  assign day    = {1'b0, day_q} + 6'd1;
  assign hour   = hr_q;
  assign minute = min_q;
  assign second = sec_q;

  // R3: capture then epoch removal comes first
  p_capture_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (phase_q == PH_EPOCH) && (rem_q == $past(units_in)));

  // R5: equal remainder never advances the year
  p_strict_year_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_YEAR) && (rem_q == len_cur)) |=> (phase_q == PH_MONTH) && $stable(yr_q));

  // R6: month index stays inside the table
  p_month_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_q <= 4'd11);

  // R7: hour phase works on less than one day
  p_day_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOUR) |-> (rem_q < CNT_W'(UNITS_DAY)));

  // R8: seconds stage sees less than one minute of units
  p_sec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |-> (rem_q < CNT_W'(UNITS_MIN)));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a busy start never restarts the sequence
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ignore |=> (phase_q != PH_EPOCH));

  // R11: idle results hold
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_IDLE) && !start) |=> $stable(yr_q) && $stable(mon_q) && $stable(day_q)
      && $stable(hr_q) && $stable(min_q) && $stable(sec_q));

  // R4: a peel step always lowers the remainder
  p_peel_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_peel |=> (rem_q < $past(rem_q)));

endmodule

// File: tb/elapsed_cal_conv_bench.sv
`timescale 1ns/1ps
module elapsed_cal_conv_bench;

  localparam int unsigned EY  = 2000;
  localparam logic [31:0] OFS = 32'd1000000;
  localparam longint      DU  = 43200;

  typedef struct {
    int     yr, mo, dy, hh, mi, ss, lat;
    longint acc;
    string  tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] units = '0;
  logic [15:0] frac = '0;
  logic        busy, done;
  logic [15:0] year;
  logic [3:0]  month;
  logic [5:0]  day;
  logic [4:0]  hour;
  logic [5:0]  minute, second;

  int     n_run = 0, n_fail = 0;
  longint cyc = 0;
  exp_t   q[$];
  exp_t   last_e;
  bit     prev_done = 0;
  bit     finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  elapsed_cal_conv u_elapsed_cal_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .units_in(units), .frac_in(frac),
    .busy(busy), .done(done), .year(year), .month(month), .day(day),
    .hour(hour), .minute(minute), .second(second)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", req, act, exp);
    end
  endtask

  function automatic string fmt(input int y, m, d, h, mi, s);
    return $sformatf("%0d-%0d-%0d %0d:%0d:%0d", y, m, d, h, mi, s);
  endfunction

  // independent restatement of the calendar walk
  function automatic exp_t model(input logic [31:0] cnt, input logic [15:0] fr);
    int mdays[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    exp_t e;
    logic [31:0] d32;
    longint r, len;
    int yr, mo;
    d32 = cnt - OFS;
    r = longint'(d32);
    yr = EY;
    forever begin
      len = ((yr % 4 == 0) ? 366 : 365) * DU;
      if (r > len) begin r -= len; yr++; end
      else break;
    end
    mo = 0;
    forever begin
      len = (mdays[mo] + ((mo == 1 && yr % 4 == 0) ? 1 : 0)) * DU;
      if (r > len) begin r -= len; mo++; end
      else break;
    end
    e.yr = yr;
    e.mo = mo + 1;
    e.dy = int'(r / DU) + 1;
    r = r % DU;
    e.hh = int'(r / 1800);
    r = r % 1800;
    e.mi = int'(r / 30);
    r = r % 30;
    e.ss = int'(r) * 2 + (fr[15] ? 1 : 0);
    e.lat = (yr - EY) + mo + (e.dy - 1) + e.hh + e.mi + 7;
    e.acc = 0;
    e.tag = "";
    return e;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] u, input logic [15:0] f, input string tag);
    exp_t e;
    wait_idle();
    units = u; frac = f; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    e = model(u, f);
    e.acc = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expected results as done pulses appear
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (prev_done)
          chk(!done, "R9", $sformatf("done=%0b after pulse", done), "done=0");
        if (done) begin
          if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected done", "no done");
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(year == 16'(e.yr) && month == 4'(e.mo) && day == 6'(e.dy) &&
                hour == 5'(e.hh) && minute == 6'(e.mi) && second == 6'(e.ss), e.tag,
                fmt(int'(year), int'(month), int'(day), int'(hour), int'(minute), int'(second)),
                fmt(e.yr, e.mo, e.dy, e.hh, e.mi, e.ss));
            chk((cyc - e.acc) == longint'(e.lat), "R9",
                $sformatf("latency %0d", cyc - e.acc), $sformatf("latency %0d", e.lat));
            last_e = e;
          end
        end
        prev_done = done;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    bit quiet;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!busy && !done && year == 16'(EY) && month == 4'd1 && day == 6'd1 &&
        hour == 5'd0 && minute == 6'd0 && second == 6'd0, "R1",
        fmt(int'(year), int'(month), int'(day), int'(hour), int'(minute), int'(second)),
        fmt(EY, 1, 1, 0, 0, 0));

    launch(OFS, 16'h0000, "R3 epoch origin");
    @(negedge clk);
    chk(busy, "R2", $sformatf("busy=%0b", busy), "busy=1");
    launch(OFS + 32'(366 * DU), 16'h0000, "R5 year length equal");
    launch(OFS + 32'(366 * DU) + 32'd1, 16'h0000, "R4 next year");
    launch(OFS + 32'(31 * DU), 16'h0000, "R5 month length equal");
    launch(OFS + 32'(59 * DU + 5 * 1800 + 7 * 30 + 3), 16'h8000, "R6 leap february");
    launch(OFS + 32'((366 + 59) * DU + 100), 16'h7FFF, "R6 common february R8");
    launch(OFS + 32'd123456789, 16'hC000, "R7 mid range");
    launch(32'd0, 16'h8001, "R3 wraparound");
    launch(OFS + 32'((366 + 365 + 365 + 365) * DU + 40 * DU + 23 * 1800 + 59 * 30 + 29),
           16'hFFFF, "R8 last second");

    // R10: start in the middle of a conversion
    launch(32'hFFFF_FFFF, 16'hFFFF, "R4 long walk R10");
    repeat (3) @(negedge clk);
    units = 32'd5; frac = 16'h0; start = 1'b1;
    chk(busy, "R10", $sformatf("busy=%0b", busy), "busy=1");
    @(negedge clk) start = 1'b0;
    wait_idle();

    // R10: start in the done cycle
    launch(OFS + 32'(100 * DU + 77), 16'h0000, "R7 R10 done cycle");
    do begin @(posedge clk); #1; end while (!done);
    units = 32'd42; frac = 16'h8000; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!busy, "R10", $sformatf("busy=%0b", busy), "busy=0");
    quiet = 1;
    repeat (6) begin
      @(posedge clk); #1;
      if (done || busy) quiet = 0;
    end
    chk(quiet, "R10", "activity after done-cycle start", "idle");
    // R11 hold while idle
    chk(year == 16'(last_e.yr) && month == 4'(last_e.mo) && day == 6'(last_e.dy) &&
        hour == 5'(last_e.hh) && minute == 6'(last_e.mi) && second == 6'(last_e.ss), "R11",
        fmt(int'(year), int'(month), int'(day), int'(hour), int'(minute), int'(second)),
        fmt(last_e.yr, last_e.mo, last_e.dy, last_e.hh, last_e.mi, last_e.ss));

    wait_idle();
    repeat (4) @(posedge clk);
    #1;
    chk(q.size() == 0, "R10", $sformatf("%0d pending", q.size()), "0 pending");
    summary();
  end

endmodule